// File: doc/BRIEF.md
# Clear-on-read dual frame-drop counter

This block keeps two drop statistics for an Ethernet receive path and presents them in one 32-bit read-only status word. The first statistic counts frames that the receive DMA threw away because no host buffer was free. The second counts frames that were lost because the receive FIFO overflowed. Each drop arrives as a single-cycle pulse on its own input, and each pulse adds one to its count.

Each count has a sticky overflow flag. The flag is set when the count wraps from all ones to zero. A clearing read resets a count together with its flag, and the byte-enable lane of the read selects which count is cleared. The read returns the value from before the clear. If a drop pulse lands in the same cycle as that read, the pulse is not lost: the counter restarts at one.

Software reads the word through a simple strobe interface made of an address, a read strobe, a write strobe and per-byte enables. The read data comes out registered, one cycle after the strobe.

Top module: `frame_drop_stat`

## Requirements
- R1: After reset both counts and both flags are zero, so the first read at the register offset returns 0x00000000.
- R2: Every cycle with `nobuf_drop_i` high adds one to the missed-frame count, which is reported in bits 15:0.
- R3: Every cycle with `fifo_drop_i` high adds one to the 11-bit FIFO-overflow count, which is reported in bits 27:17.
- R4: When a count at all ones takes one more event, it wraps to zero and sets its sticky flag. The missed-frame flag is bit 16 and the FIFO flag is bit 28. A flag stays set until a clearing read.
- R5: A read is a cycle with `rd_en_i` high, `wr_en_i` low and `addr_i` equal to offset 0x1020. On the clock edge of that cycle, `rdata_o` captures the whole word, so the value is visible from the next cycle onward.
- R6: A read with `be_i[0]` high clears the missed-frame count and its flag after the data is captured. A read with `be_i[2]` high does the same for the FIFO count and its flag. `be_i[1]` and `be_i[3]` clear nothing.
- R7: When an event and a clearing read of the same count fall in one cycle, the read returns the old value and the count ends at 1 with its flag clear.
- R8: Writes have no effect on either count, and neither do reads at any other offset. A read at another offset returns zero.
- R9: Bits 31:29 of `rdata_o` always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nobuf_drop_i | input | 1 | One-cycle pulse for each frame dropped because no host buffer was free |
| fifo_drop_i | input | 1 | One-cycle pulse for each frame lost to receive FIFO overflow |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe (accepted, has no effect) |
| addr_i | input | 13 | Byte offset of the access |
| be_i | input | 4 | Byte-lane enables of the access |
| rdata_o | output | 32 | Registered read data |

## Verification
The hardest state to reach from the ports is the wrap of the 16-bit missed-frame count. The bench reaches it with 65,538 back-to-back drop pulses and then checks that the low bits show 2 and that bit 16 is set. The 11-bit FIFO count is wrapped the same way with 2,051 pulses. A second case that is hard to hit is a drop pulse landing exactly in the cycle of a clearing read. The bench drives the pulse and the read strobe on the same falling edge, then reads the word again to confirm that the count restarted at one.

// File: rtl/frame_drop_pkg.sv
package frame_drop_pkg;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned BE_W        = DATA_W / 8;
    localparam int unsigned MISS_CNT_W  = 16;
    localparam int unsigned FIFO_CNT_W  = 11;
    localparam int unsigned REG_ADDR_W  = 13;
    localparam logic [REG_ADDR_W-1:0] STAT_OFFSET = 13'h1020;
    localparam int unsigned MISS_LANE   = 0;
    localparam int unsigned FIFO_LANE   = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_HIT   = 2'd1,
        ACC_MISS  = 2'd2,
        ACC_WRITE = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/drop_counter.sv
module drop_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            // clear takes priority, but an event in the same cycle survives
            st_d.cnt = inc_i ? CNT_ONE : '0;
            st_d.ovf = 1'b0;
        end else if (inc_i) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
            if (st_q.cnt == CNT_MAX) begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;
endmodule

// File: rtl/stat_read_port.sv
module stat_read_port
    import frame_drop_pkg::*;
#(
    parameter int unsigned ADDR_W    = REG_ADDR_W,
    parameter logic [ADDR_W-1:0] OFFSET = STAT_OFFSET,
    parameter int unsigned MISS_W    = MISS_CNT_W,
    parameter int unsigned FIFO_W    = FIFO_CNT_W,
    parameter int unsigned MISS_CLR  = MISS_LANE,
    parameter int unsigned FIFO_CLR  = FIFO_LANE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic [MISS_W-1:0] miss_cnt_i,
    input  logic              miss_ovf_i,
    input  logic [FIFO_W-1:0] fifo_cnt_i,
    input  logic              fifo_ovf_i,
    output logic              clr_miss_o,
    output logic              clr_fifo_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned MISS_LSB  = 0;
    localparam int unsigned MISS_FLAG = MISS_LSB + MISS_W;
    localparam int unsigned FIFO_LSB  = MISS_FLAG + 1;
    localparam int unsigned FIFO_FLAG = FIFO_LSB + FIFO_W;
    localparam int unsigned USED_W    = FIFO_FLAG + 1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t  rs_d, rs_q;
    acc_kind_e  kind;
    logic [DATA_W-1:0] word;

    always_comb begin
        kind = ACC_IDLE;
        if (wr_en_i) begin
            kind = ACC_WRITE;
        end else if (rd_en_i) begin
            kind = (addr_i == OFFSET) ? ACC_HIT : ACC_MISS;
        end
    end

    always_comb begin
        word = '0;
        word[MISS_LSB +: MISS_W] = miss_cnt_i;
        word[MISS_FLAG]          = miss_ovf_i;
        word[FIFO_LSB +: FIFO_W] = fifo_cnt_i;
        word[FIFO_FLAG]          = fifo_ovf_i;
    end

    always_comb begin
        rs_d       = rs_q;
        clr_miss_o = 1'b0;
        clr_fifo_o = 1'b0;
        case (kind)
            ACC_HIT: begin
                rs_d.rdata = word;
                clr_miss_o = be_i[MISS_CLR];
                clr_fifo_o = be_i[FIFO_CLR];
            end
            ACC_MISS: begin
                rs_d.rdata = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    generate
        if (USED_W < DATA_W) begin : g_pad
            assign rdata_o = {{(DATA_W-USED_W){1'b0}}, rs_q.rdata[USED_W-1:0]};
        end else begin : g_full
            assign rdata_o = rs_q.rdata;
        end
    endgenerate
endmodule

// File: rtl/frame_drop_stat.sv
module frame_drop_stat
    import frame_drop_pkg::*;
#(
    parameter int unsigned ADDR_W = REG_ADDR_W,
    parameter int unsigned MISS_W = MISS_CNT_W,
    parameter int unsigned FIFO_W = FIFO_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nobuf_drop_i,
    input  logic              fifo_drop_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BE_W-1:0]   be_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [MISS_W-1:0] miss_cnt;
    logic [FIFO_W-1:0] fifo_cnt;
    logic              miss_ovf;
    logic              fifo_ovf;
    logic              clr_miss;
    logic              clr_fifo;

    drop_counter #(.CNT_W(MISS_W)) u_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (nobuf_drop_i),
        .clr_i (clr_miss),
        .cnt_o (miss_cnt),
        .ovf_o (miss_ovf)
    );

    drop_counter #(.CNT_W(FIFO_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (fifo_drop_i),
        .clr_i (clr_fifo),
        .cnt_o (fifo_cnt),
        .ovf_o (fifo_ovf)
    );

    stat_read_port #(
        .ADDR_W (ADDR_W),
        .OFFSET (STAT_OFFSET[ADDR_W-1:0]),
        .MISS_W (MISS_W),
        .FIFO_W (FIFO_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en_i),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .be_i       (be_i),
        .miss_cnt_i (miss_cnt),
        .miss_ovf_i (miss_ovf),
        .fifo_cnt_i (fifo_cnt),
        .fifo_ovf_i (fifo_ovf),
        .clr_miss_o (clr_miss),
        .clr_fifo_o (clr_fifo),
        .rdata_o    (rdata_o)
    );
endmodule

// File: rtl/frame_drop_stat_chk.sv
module frame_drop_stat_chk
    import frame_drop_pkg::*;
#(
    parameter int unsigned MISS_W = MISS_CNT_W,
    parameter int unsigned FIFO_W = FIFO_CNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nobuf_drop_i,
    input logic              fifo_drop_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [MISS_W-1:0] miss_cnt,
    input logic [FIFO_W-1:0] fifo_cnt,
    input logic              miss_ovf,
    input logic              fifo_ovf,
    input logic              clr_miss,
    input logic              clr_fifo
);
    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:DATA_W-3] == 3'b000);

    p_miss_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (nobuf_drop_i && !clr_miss && !(&miss_cnt)) |=> miss_cnt == $past(miss_cnt) + 1'b1);

    p_fifo_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_drop_i && !clr_fifo && !(&fifo_cnt)) |=> fifo_cnt == $past(fifo_cnt) + 1'b1);

    p_miss_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nobuf_drop_i && !clr_miss && (&miss_cnt)) |=> (miss_cnt == '0) && miss_ovf);

    p_fifo_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ovf && !clr_fifo) |=> fifo_ovf);

    p_clear_keeps_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_miss && nobuf_drop_i) |=> (miss_cnt == 1) && !miss_ovf);

    p_write_no_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> !clr_miss && !clr_fifo);

    p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!nobuf_drop_i && !fifo_drop_i && !clr_miss && !clr_fifo)
        |=> $stable(miss_cnt) && $stable(fifo_cnt));
endmodule

bind frame_drop_stat frame_drop_stat_chk #(.MISS_W(MISS_W), .FIFO_W(FIFO_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .nobuf_drop_i (nobuf_drop_i),
    .fifo_drop_i  (fifo_drop_i),
    .wr_en_i      (wr_en_i),
    .rdata_o      (rdata_o),
    .miss_cnt     (miss_cnt),
    .fifo_cnt     (fifo_cnt),
    .miss_ovf     (miss_ovf),
    .fifo_ovf     (fifo_ovf),
    .clr_miss     (clr_miss),
    .clr_fifo     (clr_fifo)
);

// File: tb/frame_drop_stat_tb_top.sv
module frame_drop_stat_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nobuf_drop_i = 1'b0;
    logic        fifo_drop_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [12:0] addr_i = 13'h0;
    logic [3:0]  be_i = 4'h0;
    logic [31:0] rdata_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model
    int unsigned m_miss = 0;
    int unsigned m_fifo = 0;
    bit          m_movf = 0;
    bit          m_fovf = 0;

    localparam logic [12:0] REG_ADDR = 13'h1020;

    always #4 clk = ~clk;

    frame_drop_stat dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .nobuf_drop_i (nobuf_drop_i),
        .fifo_drop_i  (fifo_drop_i),
        .rd_en_i      (rd_en_i),
        .wr_en_i      (wr_en_i),
        .addr_i       (addr_i),
        .be_i         (be_i),
        .rdata_o      (rdata_o)
    );

    function automatic logic [31:0] model_word();
        return {3'b000, m_fovf, m_fifo[10:0], m_movf, m_miss[15:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic pulse_miss(input int n);
        for (int i = 0; i < n; i++) begin
            nobuf_drop_i = 1'b1;
            @(negedge clk);
            if (m_miss == 16'hFFFF) begin m_miss = 0; m_movf = 1; end
            else m_miss++;
        end
        nobuf_drop_i = 1'b0;
    endtask

    task automatic pulse_fifo(input int n);
        for (int i = 0; i < n; i++) begin
            fifo_drop_i = 1'b1;
            @(negedge clk);
            if (m_fifo == 11'h7FF) begin m_fifo = 0; m_fovf = 1; end
            else m_fifo++;
        end
        fifo_drop_i = 1'b0;
    endtask

    // read at the register; data is visible from the next falling edge
    task automatic rd(input logic [3:0] be, output logic [31:0] data);
        rd_en_i = 1'b1; addr_i = REG_ADDR; be_i = be;
        @(negedge clk);
        rd_en_i = 1'b0; be_i = 4'h0;
        data = rdata_o;
        if (be[0]) begin m_miss = 0; m_movf = 0; end
        if (be[2]) begin m_fifo = 0; m_fovf = 0; end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 rdata after reset", rdata_o, 32'h0);
        rd(4'h0, d);
        check("R1 first read", d, 32'h0);
    endtask

    task automatic t_count_and_clear();
        logic [31:0] d, exp;
        pulse_miss(5);
        pulse_fifo(3);
        exp = model_word();
        rd(4'h0, d);
        check("R2 R3 R5 counts", d, exp);
        check("R2 value 5", {16'h0, d[15:0]}, 32'd5);
        check("R3 value 3", {21'h0, d[27:17]}, 32'd3);
        rd(4'h0, d);
        check("R6 non-clearing read", d, exp);
        rd(4'b0101, d);
        check("R6 clearing read returns old", d, exp);
        rd(4'h0, d);
        check("R6 both cleared", d, 32'h0);
    endtask

    task automatic t_lane_select();
        logic [31:0] d, exp;
        pulse_miss(7);
        pulse_fifo(9);
        rd(4'b1010, d);
        check("R6 lanes 1 and 3 clear nothing", d, model_word());
        exp = model_word();
        rd(4'b0001, d);
        check("R6 lane0 read", d, exp);
        rd(4'h0, d);
        check("R6 lane0 cleared miss only", d, {4'h0, 11'd9, 1'b0, 16'd0});
        rd(4'b0100, d);
        rd(4'h0, d);
        check("R6 lane2 cleared fifo", d, 32'h0);
    endtask

    task automatic t_wrap_miss();
        logic [31:0] d;
        pulse_miss(65536 + 2);
        rd(4'h0, d);
        check("R4 miss wrap flag", d, 32'h0001_0002);
        pulse_miss(1);
        rd(4'h0, d);
        check("R4 miss flag sticky", d, 32'h0001_0003);
        rd(4'b0001, d);
        rd(4'h0, d);
        check("R4 R6 miss flag cleared", d, 32'h0);
    endtask

    task automatic t_wrap_fifo();
        logic [31:0] d;
        pulse_fifo(2048 + 3);
        rd(4'h0, d);
        check("R4 fifo wrap flag", d, {3'b000, 1'b1, 11'd3, 1'b0, 16'd0});
        check("R9 reserved zero", {29'h0, d[31:29]}, 32'h0);
        rd(4'b0100, d);
        rd(4'h0, d);
        check("R4 R6 fifo flag cleared", d, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        pulse_miss(4);
        pulse_fifo(2);
        rd_en_i = 1'b1; addr_i = REG_ADDR; be_i = 4'b0101;
        nobuf_drop_i = 1'b1; fifo_drop_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0; be_i = 4'h0; nobuf_drop_i = 1'b0; fifo_drop_i = 1'b0;
        check("R7 read returns old", rdata_o, {4'h0, 11'd2, 1'b0, 16'd4});
        m_miss = 1; m_movf = 0; m_fifo = 1; m_fovf = 0;
        rd(4'h0, d);
        check("R7 counts restart at one", d, {4'h0, 11'd1, 1'b0, 16'd1});
        rd(4'b0101, d);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        pulse_miss(6);
        wr_en_i = 1'b1; addr_i = REG_ADDR; be_i = 4'hF;
        @(negedge clk);
        wr_en_i = 1'b1; rd_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; rd_en_i = 1'b0; be_i = 4'h0;
        rd_en_i = 1'b1; addr_i = 13'h1024; be_i = 4'hF;
        @(negedge clk);
        rd_en_i = 1'b0; be_i = 4'h0;
        check("R8 other offset reads zero", rdata_o, 32'h0);
        rd(4'h0, d);
        check("R8 write and stray read ignored", d, 32'd6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count_and_clear();
        t_lane_select();
        t_wrap_miss();
        t_wrap_fifo();
        t_same_cycle();
        t_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule